// File: doc/BRIEF.md
# Receive Frame Status Classifier

This block sits beside an Ethernet receive path and watches the byte stream that arrives from the PHY side, one byte per clock when `rx_valid` is high. The last byte of a frame is marked by `rx_last`. On that same byte the CRC checker reports whether the frame's CRC failed (`crc_bad`) and whether the frame ended on a partial octet (`partial_octet`). Throughout the frame, PHY character errors arrive on `rx_err` and DMA bus overruns arrive on `dma_ovr`.

When a frame ends, the block issues a one-cycle status word. The word classifies the frame: CRC error, alignment error, out of buffer space, overrun, runt, type frame and PHY error. The block counts the frame's bytes and compares the count against the buffer size supplied for that frame. It decodes the type/length field, and it keeps a saturating counter of CRC-class errors.

The `save_bad` mode decides what happens to error frames. With it high, the error bits are reported. With it low, those bits are suppressed and a `discard` strobe tells the receive logic to drop the frame.

Top module: `rx_frame_status`

## Requirements
- R1: `stat_valid` is high for exactly the one cycle that follows the clock edge that accepts a byte with `rx_valid` and `rx_last` both high. `stat_word` and `discard` read zero in every other cycle.
- R2: In the status word, bit 11 is CRC error, bit 10 is alignment, bit 9 is no-resource, bit 8 is overrun, bit 7 is short frame, bit 5 is type frame and bit 4 is PHY error. All other bits of the 16-bit word, including the reserved bits 12, 6 and 3, read zero.
- R3: The frame length is the number of valid bytes from the first byte to the last, including the 4 CRC bytes. A length below 64 sets bit 7.
- R4: The type/length value is byte 12 (high half) and byte 13 (low half), with bytes counted from 0. A value of 0, or a value greater than 1500, sets bit 5. A frame of fewer than 14 bytes never sets bit 5.
- R5: `rx_err` high on any valid byte of a frame sets bit 4.
- R6: `crc_bad` high on the last byte sets bit 11 when `partial_octet` is low on that byte, and sets bit 10 when it is high. The two bits are never set together.
- R7: `dma_ovr` high on any valid byte of a frame sets bit 8.
- R8: A frame length greater than `buf_size`, sampled on the last byte, sets bit 9. A length equal to `buf_size` does not.
- R9: `save_bad` is sampled on the last byte. When it is low, bits 11, 10, 8, 7 and 4 read zero. In that case `discard` is high together with `stat_valid` whenever any of those five conditions held. `discard` is never high while `save_bad` is high. Bits 9 and 5 are not affected by the mode.
- R10: `crc_err_cnt` increases by one for each frame whose reported word has bit 4 or bit 11 set. The new count is visible in the same cycle as that frame's `stat_valid`.
- R11: `crc_err_cnt` stops at all ones and does not wrap.
- R12: The first valid byte after a frame ends starts a new frame with cleared error and length state. `rx_err` and `dma_ovr` are ignored while `rx_valid` is low.
- R13: After reset, `stat_valid`, `stat_word`, `discard` and `crc_err_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Last byte of frame, qualified by rx_valid |
| rx_err | input | 1 | PHY character error on this byte |
| dma_ovr | input | 1 | DMA could not acquire the bus on this byte |
| crc_bad | input | 1 | CRC check failed, sampled on the last byte |
| partial_octet | input | 1 | Frame ended on a partial octet, sampled on the last byte |
| save_bad | input | 1 | Report error frames instead of discarding them |
| buf_size | input | LEN_W | Receive buffer size in bytes for this frame |
| stat_valid | output | 1 | Status word strobe |
| stat_word | output | 16 | Frame status word |
| discard | output | 1 | Drop this frame (save_bad low and an error was seen) |
| crc_err_cnt | output | CNT_W | Saturating CRC/PHY error count |

## Verification
Directed frames walk the decision edges one at a time:
- lengths of 63 and 64 bytes;
- type values of 0, 1500 and 1501;
- a frame too short to carry the type field;
- a length equal to the buffer size and one byte past it;
- a CRC failure with and without a partial octet.

Each of these shows a single status bit switching on or off. Each error source is sent twice, once with save-bad mode on and once with it off, which separates reporting from discarding. Error noise is driven between frames, and a clean frame follows an error frame back to back, which shows that state does not leak from one frame to the next. Random frames then mix every source, and a run of PHY-error frames drives the counter into saturation.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int STAT_W  = 16;
  localparam int B_CRC   = 11;
  localparam int B_ALIGN = 10;
  localparam int B_NORES = 9;
  localparam int B_OVR   = 8;
  localparam int B_SHORT = 7;
  localparam int B_TYPE  = 5;
  localparam int B_PHY   = 4;
  // Bits suppressed when bad frames are not saved
  localparam logic [STAT_W-1:0] GATED_MASK = 16'h0D90;
  // Bits that may ever be set
  localparam logic [STAT_W-1:0] LIVE_MASK  = 16'h0FB0;

  typedef struct packed {
    logic crc;
    logic align;
    logic nores;
    logic ovr;
    logic runt;
    logic type_f;
    logic phy;
  } rfs_flags_t;
endpackage

// File: rtl/rfs_len_track.sv
module rfs_len_track #(
  parameter int LEN_W    = 16,
  parameter int TYPE_OFS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_last,
  input  logic [7:0]       rx_data,
  output logic             frm_start,
  output logic [LEN_W-1:0] len_nxt,
  output logic [15:0]      type_nxt,
  output logic             type_full_nxt
);
  localparam logic [LEN_W-1:0] OFS_HI = LEN_W'(TYPE_OFS);
  localparam logic [LEN_W-1:0] OFS_LO = LEN_W'(TYPE_OFS + 1);
  localparam logic [LEN_W-1:0] FULL_N = LEN_W'(TYPE_OFS + 2);

  logic             in_frame_q, in_frame_d;
  logic [LEN_W-1:0] cnt_q, base;
  logic [15:0]      type_q;

  always_comb begin
    frm_start = rx_valid & ~in_frame_q;
    base      = frm_start ? '0 : cnt_q;
    len_nxt   = (&base) ? base : base + 1'b1;
    type_nxt  = frm_start ? 16'h0 : type_q;
    if (base == OFS_HI) type_nxt[15:8] = rx_data;
    if (base == OFS_LO) type_nxt[7:0]  = rx_data;
    type_full_nxt = (len_nxt >= FULL_N);
    in_frame_d    = rx_valid ? ~rx_last : in_frame_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      type_q     <= '0;
    end else if (rx_valid) begin
      in_frame_q <= in_frame_d;
      cnt_q      <= len_nxt;
      type_q     <= type_nxt;
    end
  end
endmodule

// File: rtl/rfs_err_sticky.sv
module rfs_err_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic         frm_start,
  input  logic [N-1:0] flag_in,
  output logic [N-1:0] flag_nxt
);
  logic [N-1:0] seen_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      flag_nxt[i] = (frm_start ? 1'b0 : seen_q[i]) | (rx_valid & flag_in[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seen_q[i] <= 1'b0;
      else if (rx_valid) seen_q[i] <= flag_nxt[i];
    end
  end
endmodule

// File: rtl/rfs_status_fmt.sv
module rfs_status_fmt
  import rfs_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int MIN_LEN  = 64,
  parameter int TYPE_MAX = 1500
) (
  input  logic [LEN_W-1:0]  len,
  input  logic [15:0]       type_val,
  input  logic              type_full,
  input  logic              phy_seen,
  input  logic              ovr_seen,
  input  logic              crc_bad,
  input  logic              partial_octet,
  input  logic              save_bad,
  input  logic [LEN_W-1:0]  buf_size,
  output logic [STAT_W-1:0] word,
  output logic              discard,
  output logic              crc_evt
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [15:0]      TMAX  = 16'(TYPE_MAX);

  rfs_flags_t raw;
  logic       any_gated;

  always_comb begin
    raw.crc    = crc_bad & ~partial_octet;
    raw.align  = crc_bad &  partial_octet;
    raw.nores  = (len > buf_size);
    raw.ovr    = ovr_seen;
    raw.runt   = (len < MIN_L);
    raw.type_f = type_full & ((type_val == 16'h0) | (type_val > TMAX));
    raw.phy    = phy_seen;

    any_gated = raw.crc | raw.align | raw.ovr | raw.runt | raw.phy;

    word          = '0;
    word[B_NORES] = raw.nores;
    word[B_TYPE]  = raw.type_f;
    word[B_CRC]   = save_bad & raw.crc;
    word[B_ALIGN] = save_bad & raw.align;
    word[B_OVR]   = save_bad & raw.ovr;
    word[B_SHORT] = save_bad & raw.runt;
    word[B_PHY]   = save_bad & raw.phy;

    discard = ~save_bad & any_gated;
    crc_evt = word[B_CRC] | word[B_PHY];
  end
endmodule

// File: rtl/rfs_sat_cnt.sv
module rfs_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = inc & ~(&cnt_q);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
  import rfs_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 16,
  parameter int MIN_LEN  = 64,
  parameter int TYPE_MAX = 1500,
  parameter int TYPE_OFS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_err,
  input  logic              dma_ovr,
  input  logic              crc_bad,
  input  logic              partial_octet,
  input  logic              save_bad,
  input  logic [LEN_W-1:0]  buf_size,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat_word,
  output logic              discard,
  output logic [CNT_W-1:0]  crc_err_cnt
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic             frm_start, type_full;
  logic [LEN_W-1:0] len_nxt;
  logic [15:0]      type_nxt;
  logic [1:0]       err_nxt;
  logic [STAT_W-1:0] word_c;
  logic             disc_c, crc_evt_c, end_evt;

  rfs_len_track #(.LEN_W(LEN_W), .TYPE_OFS(TYPE_OFS)) u_len (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .rx_valid     (rx_valid),
    .rx_last      (rx_last),
    .rx_data      (rx_data),
    .frm_start    (frm_start),
    .len_nxt      (len_nxt),
    .type_nxt     (type_nxt),
    .type_full_nxt(type_full)
  );

  rfs_err_sticky #(.N(2)) u_err (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rx_valid (rx_valid),
    .frm_start(frm_start),
    .flag_in  ({dma_ovr, rx_err}),
    .flag_nxt (err_nxt)
  );

  rfs_status_fmt #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .TYPE_MAX(TYPE_MAX)) u_fmt (
    .len          (len_nxt),
    .type_val     (type_nxt),
    .type_full    (type_full),
    .phy_seen     (err_nxt[0]),
    .ovr_seen     (err_nxt[1]),
    .crc_bad      (crc_bad),
    .partial_octet(partial_octet),
    .save_bad     (save_bad),
    .buf_size     (buf_size),
    .word         (word_c),
    .discard      (disc_c),
    .crc_evt      (crc_evt_c)
  );

  assign end_evt = rx_valid & rx_last;

  rfs_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .inc  (end_evt & crc_evt_c),
    .count(crc_err_cnt)
  );

  logic              valid_d, disc_d;
  logic [STAT_W-1:0] word_d;

  always_comb begin
    valid_d = end_evt;
    word_d  = end_evt ? word_c : '0;
    disc_d  = end_evt & disc_c;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stat_valid <= 1'b0;
      stat_word  <= '0;
      discard    <= 1'b0;
    end else begin
      stat_valid <= valid_d;
      stat_word  <= word_d;
      discard    <= disc_d;
    end
  end
endmodule

// File: rtl/rx_frame_status_chk.sv
module rx_frame_status_chk
  import rfs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              rx_valid,
  input logic              rx_last,
  input logic              save_bad,
  input logic              stat_valid,
  input logic [STAT_W-1:0] stat_word,
  input logic              discard,
  input logic [CNT_W-1:0]  crc_err_cnt
);
  a_r1_pulse_on_end: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && rx_last) |=> stat_valid);
  a_r1_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rx_valid && rx_last) |=> !stat_valid);
  a_r1_word_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !stat_valid |-> (stat_word == '0 && !discard));
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_word & ~LIVE_MASK) == '0);
  a_r6_crc_align_excl: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(stat_word[B_CRC] && stat_word[B_ALIGN]));
  a_r9_discard_hides_errors: assert property (@(posedge clk) disable iff (!rst_sync_n)
    discard |-> (stat_valid && (stat_word & GATED_MASK) == '0));
  a_r9_discard_mode: assert property (@(posedge clk) disable iff (!rst_sync_n)
    discard |-> !$past(save_bad));
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (crc_err_cnt != $past(crc_err_cnt)) |-> (crc_err_cnt == CNT_W'($past(crc_err_cnt) + 1'b1)));
  a_r10_count_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (crc_err_cnt != $past(crc_err_cnt)) |-> (stat_valid && (stat_word[B_PHY] || stat_word[B_CRC])));
  a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (&$past(crc_err_cnt)) |-> (&crc_err_cnt));
endmodule

bind rx_frame_status rx_frame_status_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .rx_valid   (rx_valid),
  .rx_last    (rx_last),
  .save_bad   (save_bad),
  .stat_valid (stat_valid),
  .stat_word  (stat_word),
  .discard    (discard),
  .crc_err_cnt(crc_err_cnt)
);

// File: tb/tb_rx_frame_status.sv
module tb_rx_frame_status;
  localparam int LEN_W = 16;
  localparam int CNT_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0, dma_ovr = 1'b0;
  logic              crc_bad = 1'b0, partial_octet = 1'b0, save_bad = 1'b0;
  logic [7:0]        rx_data = '0;
  logic [LEN_W-1:0]  buf_size = '0;
  logic              stat_valid, discard;
  logic [15:0]       stat_word;
  logic [CNT_W-1:0]  crc_err_cnt;

  int n_chk = 0, n_fail = 0;
  int exp_cnt = 0;
  logic [15:0] obs_word;

  always #5 clk = ~clk;

  rx_frame_status #(.LEN_W(LEN_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err), .dma_ovr(dma_ovr), .crc_bad(crc_bad),
    .partial_octet(partial_octet), .save_bad(save_bad), .buf_size(buf_size),
    .stat_valid(stat_valid), .stat_word(stat_word), .discard(discard),
    .crc_err_cnt(crc_err_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(int len, int tf, bit phy, bit ovr,
      bit crc, bit part, bit sb, int bsz);
    logic [15:0] w = '0;
    w[5]  = (len >= 14) && (tf == 0 || tf > 1500);
    w[9]  = len > bsz;
    w[11] = sb & crc & ~part;
    w[10] = sb & crc & part;
    w[8]  = sb & ovr;
    w[7]  = sb & (len < 64);
    w[4]  = sb & phy;
    return w;
  endfunction

  function automatic string req_of(logic [15:0] d);
    if (d[11] | d[10]) return "R6";
    if (d[9]) return "R8";
    if (d[8]) return "R7";
    if (d[7]) return "R3";
    if (d[5]) return "R4";
    if (d[4]) return "R5";
    return "R2";
  endfunction

  // Called and returns at a falling edge. phy_pos/ovr_pos < 0 means none.
  task automatic send_frame(int len, int tf, int phy_pos, int ovr_pos, bit crc,
                            bit part, bit sb, int bsz, int gap, bit noise);
    logic [15:0] ew;
    bit ed;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1;
      rx_last  = (i == len - 1);
      rx_data  = (i == 12) ? 8'(tf >> 8) : (i == 13) ? 8'(tf) : 8'($urandom);
      rx_err   = (i == phy_pos);
      dma_ovr  = (i == ovr_pos);
      crc_bad  = rx_last ? crc : 1'($urandom);
      partial_octet = rx_last ? part : 1'($urandom);
      save_bad = rx_last ? sb : 1'($urandom);
      buf_size = rx_last ? LEN_W'(bsz) : LEN_W'($urandom);
      @(posedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0; dma_ovr = 1'b0;
    ew = exp_word(len, tf, phy_pos >= 0, ovr_pos >= 0, crc, part, sb, bsz);
    ed = !sb && (crc || ovr_pos >= 0 || len < 64 || phy_pos >= 0);
    if ((ew[4] | ew[11]) && exp_cnt < (1 << CNT_W) - 1) exp_cnt++;
    obs_word = stat_word;
    chk(stat_valid === 1'b1, "R1", "stat_valid at end", int'(stat_valid), 1);
    chk(stat_word === ew, req_of(stat_word ^ ew), "stat_word", int'(stat_word), int'(ew));
    chk(discard === ed, "R9", "discard", int'(discard), int'(ed));
    chk(crc_err_cnt === CNT_W'(exp_cnt), "R10", "crc_err_cnt", int'(crc_err_cnt), exp_cnt);
    for (int g = 0; g < gap; g++) begin
      rx_err = noise; dma_ovr = noise; crc_bad = noise;
      @(posedge clk);
      @(negedge clk);
      if (g == 0)
        chk(stat_valid === 1'b0 && stat_word === 16'h0 && discard === 1'b0, "R1",
            "idle after status", int'(stat_word), 0);
    end
    rx_err = 1'b0; dma_ovr = 1'b0; crc_bad = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(stat_valid === 1'b0 && stat_word === 16'h0 && discard === 1'b0 &&
        crc_err_cnt === '0, "R13", "reset state", int'(stat_word), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(stat_valid === 1'b0 && crc_err_cnt === '0, "R13", "after release",
        int'(crc_err_cnt), 0);

    // R3 length boundary, R4 type boundaries
    send_frame(64, 16'h0800, -1, -1, 0, 0, 1, 2000, 2, 0);
    send_frame(63, 16'h0800, -1, -1, 0, 0, 1, 2000, 2, 0);
    send_frame(70, 1500, -1, -1, 0, 0, 1, 2000, 2, 0);
    send_frame(70, 1501, -1, -1, 0, 0, 1, 2000, 2, 0);
    send_frame(70, 0, -1, -1, 0, 0, 1, 2000, 2, 0);
    send_frame(13, 0, -1, -1, 0, 0, 1, 2000, 2, 0);
    send_frame(14, 0, -1, -1, 0, 0, 1, 2000, 2, 0);
    // R8 buffer boundary
    send_frame(80, 100, -1, -1, 0, 0, 1, 80, 2, 0);
    send_frame(81, 100, -1, -1, 0, 0, 1, 80, 2, 0);
    // R6 CRC vs alignment, R5 PHY error, R7 overrun
    send_frame(90, 100, -1, -1, 1, 0, 1, 2000, 2, 0);
    send_frame(90, 100, -1, -1, 1, 1, 1, 2000, 2, 0);
    send_frame(90, 100, 0, -1, 0, 0, 1, 2000, 2, 0);
    send_frame(90, 100, 89, -1, 0, 0, 1, 2000, 2, 0);
    send_frame(90, 100, -1, 45, 0, 0, 1, 2000, 2, 0);
    // R9 mode off: each gated source discards
    send_frame(90, 100, -1, -1, 1, 0, 0, 2000, 2, 0);
    send_frame(90, 100, 10, -1, 0, 0, 0, 2000, 2, 0);
    send_frame(40, 0, -1, -1, 0, 0, 0, 20, 2, 0);
    send_frame(90, 0, -1, 3, 0, 0, 0, 50, 2, 0);
    // R12 idle noise ignored, then back-to-back clean after error
    send_frame(90, 100, -1, -1, 0, 0, 1, 2000, 5, 1);
    send_frame(90, 100, -1, -1, 0, 0, 1, 2000, 1, 0);
    chk(obs_word[4] === 1'b0 && obs_word[8] === 1'b0, "R12", "noise leaked",
        int'(obs_word), 0);
    send_frame(70, 100, 5, 6, 1, 0, 1, 2000, 0, 0);
    send_frame(70, 100, -1, -1, 0, 0, 1, 2000, 0, 0);
    chk(obs_word === 16'h0, "R12", "state carried over", int'(obs_word), 0);
    send_frame(1, 0, -1, -1, 0, 0, 1, 2000, 0, 0);
    send_frame(1, 0, 0, -1, 0, 0, 1, 2000, 0, 0);
    send_frame(1, 0, -1, -1, 0, 0, 1, 2000, 2, 0);

    // Random mix
    for (int k = 0; k < 150; k++) begin
      int len = 1 + int'($urandom_range(0, 119));
      int tf  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1495, 1505)) :
                ($urandom_range(0, 5) == 0) ? 0 : int'($urandom_range(0, 65535));
      int pp  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, len - 1)) : -1;
      int op  = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, len - 1)) : -1;
      send_frame(len, tf, pp, op, 1'($urandom_range(0, 3) == 0), 1'($urandom),
                 1'($urandom), int'($urandom_range(0, 130)),
                 int'($urandom_range(0, 3)), 1'($urandom));
    end

    // R11 saturation
    for (int k = 0; k < 20; k++)
      send_frame(70, 100, 2, -1, 0, 0, 1, 2000, 1, 0);
    chk(&crc_err_cnt, "R11", "counter saturated", int'(crc_err_cnt), (1 << CNT_W) - 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule